// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the fetch address of a small controller with 14-bit instructions whose code space (8192 words, a 13-bit counter) is wider than the 11-bit target field in its jump and call instructions. Each instruction slot it steps forward by one word. It can also load a new address from one of two sources. A jump or call supplies an 11-bit literal. A software write to the counter's low byte, which is visible in data space, supplies 8 bits. In both cases the missing upper address bits come from a separate 5-bit page latch that software writes on its own. The counter never writes that latch back.

The low byte of the counter can be read at any time, which lets code build computed jumps into tables of return-with-literal words. Any change of flow wastes the instruction already prefetched, and so does a skip request. The block marks that wasted slot with a dead-slot output. While the slot is dead it ignores every strobe that the discarded instruction raises. As a result, skips chain correctly: when a skip is taken, a following skip request is itself discarded. The call stack and the instruction decoder sit outside this block.

Top module: `paged_pc_unit`

## Requirements
- R1: After reset the fetch address is 0, the page latch reads 0 and no slot is marked dead.
- R2: With advance enabled and no load, the fetch address grows by one. The carry passes from bit 7 into bit 8, and 0x1FFF wraps to 0x0000. With advance low and no load, the address holds.
- R3: A jump or a call (either strobe) loads fetch address bits 10:0 from the literal and bits 12:11 from page latch bits 4:3. Latch bits 2:0 have no effect on it.
- R4: A write of the low byte loads fetch address bits 7:0 from the written byte and bits 12:8 from page latch bits 4:0.
- R5: The page latch changes only when software writes it, and it reads back the last value written, whatever the counter has done since.
- R6: Every load from R3 or R4 marks the next slot dead.
- R7: A skip request marks the next slot dead and leaves the fetch address to advance as in R2.
- R8: While a slot is dead, its jump, call, low-byte write, latch write and skip strobes are all ignored. No slot following a dead one is itself dead unless a live strobe caused it. So skip-if-A then skip-if-B then C runs C when A is taken, or when A is not taken and B is not taken.
- R9: When a jump or call and a low-byte write come in the same live slot, the jump or call wins.
- R10: A load in the same slot as a latch write uses the latch value from before that write.
- R11: The readable low byte always equals fetch address bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adv_en | input | 1 | Advance the counter this slot |
| jmp_req | input | 1 | Jump strobe |
| call_req | input | 1 | Call strobe (same address effect as a jump) |
| tgt_lit | input | 11 | Jump or call target literal |
| lowb_wr | input | 1 | Data-space write of the counter low byte |
| lowb_wdata | input | 8 | Byte written to the counter low byte |
| latch_wr | input | 1 | Write of the page latch |
| latch_wdata | input | 5 | Value written to the page latch |
| skip_req | input | 1 | Skip the next instruction |
| fetch_addr | output | 13 | Current fetch address |
| pc_low | output | 8 | Readable low byte of the counter |
| latch_q | output | 5 | Readable page latch contents |
| dead_slot | output | 1 | The instruction in this slot is discarded |

## Verification
The corner cases are these:
- The increment from 0x0FF and the wrap at 0x1FFF. A counter that dropped the carry would fall back to the start of its 256-word page.
- Jumps made with latch bits 2:0 set. A design that took the whole latch would land on the wrong 2048-word page.
- Loads that come in the same slot as a latch write. A design that used the new latch value would jump one page off.
- Chained skips, and strobes inside a dead slot. A design that let a discarded instruction through would jump, rewrite the latch or stretch the dead run to two slots.
- Long runs of increments. The page latch must still read back its written value, not the counter's upper bits.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Source selected for the next fetch address.
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_STEP  = 2'd1,
    SRC_JUMP  = 2'd2,
    SRC_TABLE = 2'd3
  } pc_src_e;
endpackage

// File: rtl/pcu_latch.sv
module pcu_latch #(
  parameter int LATCH_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [LATCH_W-1:0] wr_data,
  output logic [LATCH_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end

  // R5: the latch keeps its value unless software writes it
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int PC_W  = 13,
  parameter int JMP_W = 11,
  parameter int LOW_W = 8,
  localparam int LATCH_W = PC_W - LOW_W,
  localparam int JHI_W   = PC_W - JMP_W
) (
  input  logic [PC_W-1:0]    pc,
  input  logic [LATCH_W-1:0] latch,
  input  logic [JMP_W-1:0]   lit,
  input  logic [LOW_W-1:0]   byte_in,
  output logic [PC_W-1:0]    jump_tgt,
  output logic [PC_W-1:0]    table_tgt,
  output logic [PC_W-1:0]    step_val
);
  // Jump page: the top JHI_W bits of the latch above the literal.
  function automatic logic [PC_W-1:0] f_jump(input logic [LATCH_W-1:0] l,
                                             input logic [JMP_W-1:0] t);
    return {l[LATCH_W-1 -: JHI_W], t};
  endfunction

  // Computed jump: the whole latch above the written byte.
  function automatic logic [PC_W-1:0] f_table(input logic [LATCH_W-1:0] l,
                                              input logic [LOW_W-1:0] b);
    return {l, b};
  endfunction

  // Sequential step with full carry and natural wrap.
  function automatic logic [PC_W-1:0] f_step(input logic [PC_W-1:0] p);
    return p + PC_W'(1);
  endfunction

  always_comb begin
    jump_tgt  = f_jump(latch, lit);
    table_tgt = f_table(latch, byte_in);
    step_val  = f_step(pc);
  end
endmodule

// File: rtl/pcu_seq.sv
module pcu_seq
  import pcu_pkg::*;
#(
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pc_src_e         sel,
  input  logic            kill_next,
  input  logic [PC_W-1:0] jump_tgt,
  input  logic [PC_W-1:0] table_tgt,
  input  logic [PC_W-1:0] step_val,
  output logic [PC_W-1:0] pc_q,
  output logic            dead_q
);
  logic [PC_W-1:0] pc_d;

  always_comb begin
    unique case (sel)
      SRC_STEP:  pc_d = step_val;
      SRC_JUMP:  pc_d = jump_tgt;
      SRC_TABLE: pc_d = table_tgt;
      default:   pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      dead_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      dead_q <= kill_next;
    end
  end

  // R2: no advance and no load keeps the address
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_HOLD) |=> $stable(pc_q));
  // R2: stepping lands on the incremented value from the target logic
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_STEP) |=> (pc_q == $past(step_val)));
  // R6: every load leaves a dead slot behind it
  a_r6_load_dead: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_JUMP || sel == SRC_TABLE) |=> dead_q);
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import pcu_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int JMP_W = 11,
  parameter int LOW_W = 8,
  localparam int LATCH_W = PC_W - LOW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_en,
  input  logic               jmp_req,
  input  logic               call_req,
  input  logic [JMP_W-1:0]   tgt_lit,
  input  logic               lowb_wr,
  input  logic [LOW_W-1:0]   lowb_wdata,
  input  logic               latch_wr,
  input  logic [LATCH_W-1:0] latch_wdata,
  input  logic               skip_req,
  output logic [PC_W-1:0]    fetch_addr,
  output logic [LOW_W-1:0]   pc_low,
  output logic [LATCH_W-1:0] latch_q,
  output logic               dead_slot
);
  // Named internal events, brought out for the assertions.
  logic            live;
  logic            jump_ev;
  logic            table_ev;
  logic            skip_ev;
  logic            latch_ev;
  logic            kill_next;
  pc_src_e         sel;
  logic [PC_W-1:0] jump_tgt, table_tgt, step_val;

  always_comb begin
    live      = !dead_slot;
    jump_ev   = live && (jmp_req || call_req);
    table_ev  = live && lowb_wr && !jump_ev;
    skip_ev   = live && skip_req;
    latch_ev  = live && latch_wr;
    kill_next = jump_ev || table_ev || skip_ev;
    if (jump_ev)       sel = SRC_JUMP;
    else if (table_ev) sel = SRC_TABLE;
    else if (adv_en)   sel = SRC_STEP;
    else               sel = SRC_HOLD;
  end

  pcu_latch #(.LATCH_W(LATCH_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (latch_ev),
    .wr_data (latch_wdata),
    .q       (latch_q)
  );

  pcu_target #(.PC_W(PC_W), .JMP_W(JMP_W), .LOW_W(LOW_W)) u_target (
    .pc        (fetch_addr),
    .latch     (latch_q),
    .lit       (tgt_lit),
    .byte_in   (lowb_wdata),
    .jump_tgt  (jump_tgt),
    .table_tgt (table_tgt),
    .step_val  (step_val)
  );

  pcu_seq #(.PC_W(PC_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .kill_next (kill_next),
    .jump_tgt  (jump_tgt),
    .table_tgt (table_tgt),
    .step_val  (step_val),
    .pc_q      (fetch_addr),
    .dead_q    (dead_slot)
  );

  assign pc_low = fetch_addr[LOW_W-1:0];

  // R3: a live jump or call puts the literal in the low address bits
  a_r3_jump_low: assert property (@(posedge clk) disable iff (!rst_n)
    jump_ev |=> (fetch_addr[JMP_W-1:0] == $past(tgt_lit)));
  // R4: a live low-byte write shows up as the readable low byte
  a_r4_table_low: assert property (@(posedge clk) disable iff (!rst_n)
    table_ev |=> (pc_low == $past(lowb_wdata)));
  // R8: a dead slot never produces another dead slot
  a_r8_single_dead: assert property (@(posedge clk) disable iff (!rst_n)
    dead_slot |=> !dead_slot);
  // R8: strobes in a dead slot leave the latch alone
  a_r8_dead_latch: assert property (@(posedge clk) disable iff (!rst_n)
    dead_slot |=> $stable(latch_q));
  // R7: a live skip with advance and no load keeps stepping
  a_r7_skip_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_ev && !jump_ev && !table_ev && adv_en) |=>
      (fetch_addr == $past(fetch_addr) + PC_W'(1)) && dead_slot);
  // R11: readable low byte mirrors the counter
  a_r11_low_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    pc_low == fetch_addr[LOW_W-1:0]);
endmodule

// File: tb/test_paged_pc_unit.sv
`timescale 1ns/1ps
module test_paged_pc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_en = 1'b0, jmp_req = 1'b0, call_req = 1'b0;
  logic [10:0] tgt_lit = '0;
  logic        lowb_wr = 1'b0;
  logic [7:0]  lowb_wdata = '0;
  logic        latch_wr = 1'b0;
  logic [4:0]  latch_wdata = '0;
  logic        skip_req = 1'b0;
  logic [12:0] fetch_addr;
  logic [7:0]  pc_low;
  logic [4:0]  latch_q;
  logic        dead_slot;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state
  int m_pc = 0;
  int m_latch = 0;
  bit m_dead = 0;

  always #10 clk = ~clk;

  paged_pc_unit i_paged_pc_unit (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .jmp_req(jmp_req),
    .call_req(call_req), .tgt_lit(tgt_lit), .lowb_wr(lowb_wr),
    .lowb_wdata(lowb_wdata), .latch_wr(latch_wr), .latch_wdata(latch_wdata),
    .skip_req(skip_req), .fetch_addr(fetch_addr), .pc_low(pc_low),
    .latch_q(latch_q), .dead_slot(dead_slot)
  );

  // Address arithmetic restated in integer form.
  function automatic int exp_jump(int latch, int lit);
    return (latch / 8) * 2048 + lit;
  endfunction
  function automatic int exp_table(int latch, int b);
    return latch * 256 + b;
  endfunction
  function automatic int exp_step(int pc);
    return (pc + 1) % 8192;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "fetch_addr", int'(fetch_addr), m_pc);
    check("R11", "pc_low", int'(pc_low), m_pc % 256);
    check(req, "latch_q", int'(latch_q), m_latch);
    check(req, "dead_slot", int'(dead_slot), int'(m_dead));
  endtask

  // Drive one slot, advance the reference, compare at the next falling edge.
  task automatic slot(string req, bit adv, bit jmp, bit cal, int lit,
                      bit lw, int lb, bit xw, int xv, bit sk);
    bit live, j, t, s, l;
    adv_en = adv; jmp_req = jmp; call_req = cal; tgt_lit = 11'(lit);
    lowb_wr = lw; lowb_wdata = 8'(lb); latch_wr = xw; latch_wdata = 5'(xv);
    skip_req = sk;
    @(posedge clk);
    live = !m_dead;
    j = live && (jmp || cal);
    t = live && lw && !j;
    s = live && sk;
    l = live && xw;
    if (j)        m_pc = exp_jump(m_latch, lit);
    else if (t)   m_pc = exp_table(m_latch, lb);
    else if (adv) m_pc = exp_step(m_pc);
    m_dead = j || t || s;
    if (l) m_latch = xv;
    @(negedge clk);
    check_all(req);
  endtask

  task automatic idle(string req);
    slot(req, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R4 + R2: table load to 0x0FF, then carry into bit 8
    slot("R5", 0, 0, 0, 0, 0, 0, 1, 5'h00, 0);
    slot("R4", 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
    check("R4", "table 0x0FF", int'(fetch_addr), 13'h0FF);
    slot("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);   // dead slot, still steps
    check("R2", "carry into bit8", int'(fetch_addr), 13'h100);
    // R2: wrap at top of space
    slot("R5", 0, 0, 0, 0, 0, 0, 1, 5'h1F, 0);
    slot("R4", 0, 0, 0, 0, 1, 8'hFF, 0, 0, 0);
    check("R4", "table 0x1FFF", int'(fetch_addr), 13'h1FFF);
    slot("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2", "wrap to 0", int'(fetch_addr), 0);
    idle("R2");                                // hold with advance low
    check("R2", "hold", int'(fetch_addr), 0);

    // R3: jump page from latch bits 4:3 only
    slot("R5", 0, 0, 0, 0, 0, 0, 1, 5'h18, 0);
    slot("R3", 0, 1, 0, 11'h123, 0, 0, 0, 0, 0);
    check("R3", "jump page 3", int'(fetch_addr), 13'h1923);
    check("R6", "jump dead", int'(dead_slot), 1);
    idle("R6");
    slot("R5", 0, 0, 0, 0, 0, 0, 1, 5'h07, 0);
    slot("R3", 0, 0, 1, 11'h7FF, 0, 0, 0, 0, 0);
    check("R3", "call ignores low latch bits", int'(fetch_addr), 13'h07FF);
    idle("R3");

    // R9: jump beats low-byte write
    slot("R9", 0, 1, 0, 11'h055, 1, 8'hAA, 0, 0, 0);
    check("R9", "jump wins", int'(fetch_addr), 13'h0055);
    idle("R9");

    // R10: load with same-slot latch write uses the old latch
    slot("R10", 0, 1, 0, 11'h001, 0, 0, 1, 5'h1F, 0);
    check("R10", "old latch on jump", int'(fetch_addr), 13'h0001);
    check("R10", "latch updated", int'(latch_q), 5'h1F);
    idle("R10");

    // R8: everything ignored in a dead slot
    slot("R7", 1, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R7", "skip dead", int'(dead_slot), 1);
    check("R7", "skip steps", int'(fetch_addr), 13'h0002);
    slot("R8", 1, 1, 1, 11'h3AB, 1, 8'h11, 1, 5'h02, 1);
    check("R8", "no jump in dead", int'(fetch_addr), 13'h0003);
    check("R8", "latch kept", int'(latch_q), 5'h1F);
    check("R8", "no second dead", int'(dead_slot), 0);

    // R8: chained skips: A taken -> B squashed -> C live
    slot("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1);   // skip A taken
    slot("R8", 1, 0, 0, 0, 0, 0, 0, 0, 1);   // skip B, discarded
    check("R8", "C live after A", int'(dead_slot), 0);
    slot("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0);   // A not taken
    slot("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0);   // B not taken
    check("R8", "C live, A and B clear", int'(dead_slot), 0);

    // R5: long stepping leaves the latch untouched
    repeat (300) slot("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R5", "latch after steps", int'(latch_q), 5'h1F);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      slot("R2", ($urandom % 8) != 0, ($urandom % 10) == 0,
           ($urandom % 14) == 0, int'($urandom % 2048),
           ($urandom % 9) == 0, int'($urandom % 256),
           ($urandom % 5) == 0, int'($urandom % 32), ($urandom % 6) == 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule